// File: doc/BRIEF.md
# Dual-Address Block-Transfer DMA Engine

A single-channel DMA engine that copies data from one external memory location to another. Every unit moved is a locked pair of bus cycles: a read at the source address, then a write of the captured value to the destination address on the clock right after the read completes. No other cycle can come between them. Software programs the source address, destination address, total count, block length and mode through a small write port, sets the enable bit, and then pulses `xfer_req`. Each pulse starts one complete block.

The unit is a byte or a 16-bit word. Each address pointer can increment, decrement or hold on its own, with a step of 1 for bytes and 2 for words. Either pointer can also be confined to a repeat window of 2^N bytes. Inside that window only the low N address bits move, and the pointer wraps at both edges.

A total count of zero means the channel runs without limit. A non-zero total counts down once per unit. On the last unit the engine clears its own enable bit and raises a done flag. The end-of-transfer strobe, when it is enabled, marks both bus cycles of that final unit. The acknowledge output is never driven active.

The control sequencer has four states. S_IDLE waits for an enabled channel with a latched request. S_ARB raises the bus request and waits for the grant. S_RD is the locked read cycle. S_WR is the locked write cycle. The transitions are:
- take: S_IDLE to S_ARB.
- grant: S_ARB to S_RD.
- read-ready: S_RD to S_WR.
- next-unit: S_WR to S_ARB, when the block has units left.
- stop: S_WR to S_IDLE, when the block, the total, or the enable runs out.

Top module: `dma_engine`

## Requirements
- R1: Each request started from S_IDLE moves exactly `blk_field+1` units (1 to 256). The engine then drops `bus_req` and waits for another request.
- R2: Each unit is one read with `bus_we`=0 at the source pointer, followed by one write with `bus_we`=1 at the destination pointer. The write data is the value captured on the read. For a byte unit, data sits in bits [7:0] of the data bus.
- R3: The write cycle begins on the clock after the read cycle completes (`bus_rdy` high). `bus_lock` stays high through both cycles, and it is high only while `bus_req` is high.
- R4: The step field for each pointer is encoded as 01 = increment, 10 = decrement, 00 or 11 = hold. The step size is 1 when the mode word bit is 0 and 2 when it is 1. The pointer updates after each completed write.
- R5: When a pointer's wrap bit is set, bits [N-1:0] of that pointer move by the step modulo 2^N, and the bits above them never change. N is the shared wrap exponent.
- R6: With a total count of 0 the channel keeps moving blocks and stays enabled. With a non-zero total, the completion of the unit that brings the total to 0 clears `ch_enable`, sets `ch_done`, and ends the block early. Writing the mode register with enable=1 clears `ch_done`.
- R7: With the end-strobe bit set, `eot_strobe` is high during both the read and the write of the final unit of a non-zero total, and at no other time. With that bit clear, it never goes high.
- R8: `xfer_ack` stays low at all times.
- R9: A request that arrives while a block is in progress is held and served after that block ends. Requests that arrive while the channel is disabled are dropped.
- R10: After reset: `ch_enable`, `ch_done`, `bus_req`, `bus_lock` and `eot_strobe` are low.
- R11: Register selects: 0 = source pointer, 1 = destination pointer, 2 = total count, 3 = block field [7:0], 4 = mode. Mode bits are: [0] enable, [1] word, [3:2] source step, [5:4] destination step, [6] end-strobe enable, [7] source wrap, [8] destination wrap, [12:9] wrap exponent N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| xfer_req | input | 1 | Transfer request, one block per pulse |
| bus_gnt | input | 1 | Bus grant |
| bus_rdy | input | 1 | Current bus cycle completes |
| bus_rdata | input | 16 | Read data |
| ch_enable | output | 1 | Channel enable bit |
| ch_done | output | 1 | Total count exhausted |
| bus_req | output | 1 | Bus request |
| bus_lock | output | 1 | Locked read/write pair in progress |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = 16-bit unit, 0 = byte |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Write data |
| eot_strobe | output | 1 | End-of-transfer strobe |
| xfer_ack | output | 1 | Acknowledge, held low |

## Verification
The hardest case to reach from the ports is a pointer crossing the edge of its repeat window in both directions within one block. A related case is a non-zero total that runs out in the middle of a block, with a second request already latched behind it.

The stimulus reaches these cases in three ways:
- It places a source pointer two bytes below the top of a 4-byte window with increment, and a destination pointer at the second byte of a window with decrement. A six-unit block then crosses both edges.
- It gives a word-mode channel a total of 3 with blocks of 2 and sends a second pulse while the first block is still running. The final unit therefore falls inside the latched second block.
- It gives a channel a total of 2 with blocks of 4, so the count stops the transfer partway through the first block.

Wait states from a pseudo-random ready pattern stretch every cycle pair.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_HLD2 = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARB,
        S_RD,
        S_WR
    } seq_e;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int AW = 16,
    parameter int NW = 4
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    step,
    input  logic          word,
    input  logic          wrap_en,
    input  logic [NW-1:0] wrap_n,
    output logic [AW-1:0] nxt
);
    import dma_pkg::*;

    logic [AW-1:0] delta;
    logic [AW-1:0] raw;
    logic [AW-1:0] mask;

    always_comb begin
        delta = word ? AW'(2) : AW'(1);
        unique case (step_e'(step))
            STEP_INC: raw = cur + delta;
            STEP_DEC: raw = cur - delta;
            default:  raw = cur;
        endcase
        mask = (AW'(1) << wrap_n) - AW'(1);
        nxt  = wrap_en ? ((cur & ~mask) | (raw & mask)) : raw;
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
    parameter int CNTW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            req_in,
    input  logic            gnt,
    input  logic            rdy,
    input  logic [CNTW-1:0] units,
    input  logic            tot_last,
    output logic            st_rd,
    output logic            st_wr,
    output logic            rd_done,
    output logic            xfer_done,
    output logic            finish,
    output logic            bus_req,
    output logic            bus_lock
);
    import dma_pkg::*;

    seq_e            state_q, state_d;
    logic [CNTW-1:0] blk_q;
    logic            pend_q;
    logic            take;

    assign take = (state_q == S_IDLE) && en && pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (take) state_d = S_ARB;
            S_ARB:  if (gnt)  state_d = S_RD;
            S_RD:   if (rdy)  state_d = S_WR;
            S_WR: begin
                if (rdy) begin
                    if (tot_last || !en || blk_q == CNTW'(1)) state_d = S_IDLE;
                    else                                      state_d = S_ARB;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            blk_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= en && ((pend_q && !take) || req_in);
            if (take)           blk_q <= units;
            else if (xfer_done) blk_q <= blk_q - CNTW'(1);
        end
    end

    always_comb begin
        st_rd     = (state_q == S_RD);
        st_wr     = (state_q == S_WR);
        rd_done   = st_rd && rdy;
        xfer_done = st_wr && rdy;
        finish    = xfer_done && tot_last;
        bus_req   = (state_q != S_IDLE);
        bus_lock  = st_rd || st_wr;
    end

    p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD && rdy) |=> (state_q == S_WR && bus_lock));
    p_lock_under_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> bus_req);
    p_blk_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (blk_q != '0));
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int BW = 8,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    input  logic          xfer_req,
    input  logic          bus_gnt,
    input  logic          bus_rdy,
    input  logic [DW-1:0] bus_rdata,
    output logic          ch_enable,
    output logic          ch_done,
    output logic          bus_req,
    output logic          bus_lock,
    output logic          bus_we,
    output logic          bus_word,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          eot_strobe,
    output logic          xfer_ack
);
    localparam int CNTW   = BW + 1;
    localparam int M_NLSB = 9;

    logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic [CW-1:0] tot_q;
    logic [BW-1:0] blk_q;
    logic [DW-1:0] data_q;
    logic          en_q, done_q, word_q, eot_en_q, swrap_q, dwrap_q;
    logic [1:0]    sstep_q, dstep_q;
    logic [NW-1:0] wrap_n_q;
    logic          st_rd, st_wr, rd_done, xfer_done, finish, tot_last;
    logic [CNTW-1:0] units;

    assign units    = {1'b0, blk_q} + CNTW'(1);
    assign tot_last = (tot_q == CW'(1));

    dma_addr_gen #(.AW(AW), .NW(NW)) u_src_gen (
        .cur(src_q), .step(sstep_q), .word(word_q), .wrap_en(swrap_q),
        .wrap_n(wrap_n_q), .nxt(src_nxt));

    dma_addr_gen #(.AW(AW), .NW(NW)) u_dst_gen (
        .cur(dst_q), .step(dstep_q), .word(word_q), .wrap_en(dwrap_q),
        .wrap_n(wrap_n_q), .nxt(dst_nxt));

    dma_seq #(.CNTW(CNTW)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en_q), .req_in(xfer_req), .gnt(bus_gnt),
        .rdy(bus_rdy), .units(units), .tot_last(tot_last), .st_rd(st_rd),
        .st_wr(st_wr), .rd_done(rd_done), .xfer_done(xfer_done), .finish(finish),
        .bus_req(bus_req), .bus_lock(bus_lock));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            tot_q    <= '0;
            blk_q    <= '0;
            data_q   <= '0;
            en_q     <= 1'b0;
            done_q   <= 1'b0;
            word_q   <= 1'b0;
            eot_en_q <= 1'b0;
            swrap_q  <= 1'b0;
            dwrap_q  <= 1'b0;
            sstep_q  <= 2'b00;
            dstep_q  <= 2'b00;
            wrap_n_q <= '0;
        end else begin
            if (rd_done) data_q <= bus_rdata;
            if (xfer_done) begin
                src_q <= src_nxt;
                dst_q <= dst_nxt;
                if (tot_q != '0) tot_q <= tot_q - CW'(1);
            end
            if (finish) begin
                en_q   <= 1'b0;
                done_q <= 1'b1;
            end
            if (reg_we) begin
                case (reg_sel)
                    3'd0: src_q <= reg_wdata[AW-1:0];
                    3'd1: dst_q <= reg_wdata[AW-1:0];
                    3'd2: tot_q <= reg_wdata[CW-1:0];
                    3'd3: blk_q <= reg_wdata[BW-1:0];
                    3'd4: begin
                        en_q     <= reg_wdata[0];
                        done_q   <= done_q & ~reg_wdata[0];
                        word_q   <= reg_wdata[1];
                        sstep_q  <= reg_wdata[3:2];
                        dstep_q  <= reg_wdata[5:4];
                        eot_en_q <= reg_wdata[6];
                        swrap_q  <= reg_wdata[7];
                        dwrap_q  <= reg_wdata[8];
                        wrap_n_q <= reg_wdata[M_NLSB +: NW];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ch_enable  = en_q;
        ch_done    = done_q;
        bus_we     = st_wr;
        bus_word   = word_q;
        bus_addr   = st_wr ? dst_q : src_q;
        bus_wdata  = data_q;
        eot_strobe = eot_en_q && tot_last && (st_rd || st_wr);
        xfer_ack   = 1'b0;
    end

    p_done_clears_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !en_q);
    p_eot_in_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eot_strobe |-> bus_lock);
    p_src_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && (sstep_q[0] == sstep_q[1]) && !reg_we) |=> $stable(src_q));
    p_wrap_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && swrap_q && !reg_we) |=>
        (((src_q ^ $past(src_q)) & ~((AW'(1) << wrap_n_q) - AW'(1))) == '0));
endmodule

// File: tb/dma_engine_tb.sv
`timescale 1ns/100ps
module dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        xfer_req = 1'b0;
    logic        bus_gnt = 1'b0;
    logic        bus_rdy = 1'b0;
    logic [15:0] bus_rdata;
    logic        ch_enable, ch_done, bus_req, bus_lock, bus_we, bus_word;
    logic [15:0] bus_addr, bus_wdata;
    logic        eot_strobe, xfer_ack;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .xfer_req(xfer_req), .bus_gnt(bus_gnt),
        .bus_rdy(bus_rdy), .bus_rdata(bus_rdata), .ch_enable(ch_enable),
        .ch_done(ch_done), .bus_req(bus_req), .bus_lock(bus_lock),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .eot_strobe(eot_strobe), .xfer_ack(xfer_ack));

    function automatic logic [7:0] fill(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign bus_rdata = bus_word ? {fill(bus_addr + 16'd1), fill(bus_addr)}
                                : {8'h00, fill(bus_addr)};

    logic [7:0] lfsr = 8'hA5;
    always @(posedge clk) begin
        bus_gnt <= bus_req;
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bus_rdy <= lfsr[0] | lfsr[2];
    end

    typedef struct {
        logic [15:0] s;
        logic [15:0] d;
        logic [15:0] data;
        logic        e;
    } item_t;
    item_t q[$];

    logic [15:0] ms, md;
    int          mtot, mblk, mn;
    bit          mword, meot, msw, mdw, men;
    int          mss, mds;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mnext(input logic [15:0] a, input int st, input bit wr);
        int d, size, base, off;
        d = (st == 1) ? (mword ? 2 : 1) : (st == 2) ? (mword ? -2 : -1) : 0;
        if (!wr) return 16'(int'(a) + d);
        size = 1 << mn;
        base = int'(a) - (int'(a) % size);
        off  = ((int'(a) % size) + d + size) % size;
        return 16'(base + off);
    endfunction

    task automatic push_block();
        item_t it;
        if (!men) return;
        for (int i = 0; i < mblk + 1; i++) begin
            it.s    = ms;
            it.d    = md;
            it.data = mword ? {fill(ms + 16'd1), fill(ms)} : {8'h00, fill(ms)};
            it.e    = meot && (mtot == 1);
            q.push_back(it);
            ms = mnext(ms, mss, msw);
            md = mnext(md, mds, mdw);
            if (mtot != 0) begin
                mtot--;
                if (mtot == 0) begin
                    men = 1'b0;
                    break;
                end
            end
        end
    endtask

    logic [15:0] rd_src;
    bit          rd_eot;
    always @(negedge clk) begin
        if (rst_n && bus_lock && bus_rdy) begin
            if (!bus_we) begin
                rd_src = bus_addr;
                rd_eot = eot_strobe;
            end else if (q.size() == 0) begin
                check(1'b0, "R1 write with no expected unit", {16'h0, bus_addr}, 32'h0);
            end else begin
                item_t it;
                it = q.pop_front();
                check(rd_src == it.s, "R2/R4/R5 read address", {16'h0, rd_src}, {16'h0, it.s});
                check(bus_addr == it.d, "R2/R4/R5 write address", {16'h0, bus_addr}, {16'h0, it.d});
                check(bus_wdata == it.data, "R2 write data", {16'h0, bus_wdata}, {16'h0, it.data});
                check(rd_eot == it.e && eot_strobe == it.e, "R7 end strobe on both cycles",
                      {30'h0, rd_eot, eot_strobe}, {30'h0, it.e, it.e});
                check(xfer_ack == 1'b0, "R8 ack low", {31'h0, xfer_ack}, 32'h0);
            end
        end
    end

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        @(negedge clk);
        while ((q.size() != 0 || bus_req) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(t < 4000, "R1 watchdog: block did not complete", t, 4000);
    endtask

    task automatic setup(input logic [15:0] s, input logic [15:0] d, input int tot,
                         input int blk, input bit word, input int ss, input int ds,
                         input bit eot, input bit sw, input bit dw, input int n);
        ms = s; md = d; mtot = tot; mblk = blk; mword = word; mss = ss; mds = ds;
        meot = eot; msw = sw; mdw = dw; mn = n; men = 1'b1;
        wr_reg(3'd0, {16'h0, s});
        wr_reg(3'd1, {16'h0, d});
        wr_reg(3'd2, tot);
        wr_reg(3'd3, blk);
        wr_reg(3'd4, {19'h0, 4'(n), dw, sw, eot, 2'(ds), 2'(ss), word, 1'b1});
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check({ch_enable, ch_done, bus_req, bus_lock, eot_strobe} == 5'b0,
              "R10 reset outputs", {27'h0, ch_enable, ch_done, bus_req, bus_lock, eot_strobe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R4 R6 R11: byte, inc/inc, 4 units, endless total
        setup(16'h0100, 16'h0800, 0, 3, 1'b0, 1, 1, 1'b1, 1'b0, 1'b0, 0);
        pulse(); push_block();
        drain();
        repeat (10) @(negedge clk);
        check(!bus_req, "R1 idle after block", {31'h0, bus_req}, 0);
        check(ch_enable && !ch_done, "R6 endless stays enabled", {30'h0, ch_enable, ch_done}, 32'h2);

        // R9 R6 R7: word, src dec, dst hold, total 3, blocks of 2
        setup(16'h0200, 16'h0900, 3, 1, 1'b1, 2, 0, 1'b1, 1'b0, 1'b0, 0);
        check(!ch_done, "R6 mode write clears done", {31'h0, ch_done}, 0);
        pulse(); push_block();
        repeat (2) @(negedge clk);
        pulse(); push_block();
        drain();
        check(!ch_enable && ch_done, "R6 total exhausted", {30'h0, ch_enable, ch_done}, 32'h1);
        pulse();
        repeat (30) @(negedge clk);
        check(!bus_req, "R9 request dropped while disabled", {31'h0, bus_req}, 0);

        // R5: byte, src inc wrap, dst dec wrap, N=2, 6 units
        setup(16'h0106, 16'h0801, 0, 5, 1'b0, 1, 2, 1'b1, 1'b1, 1'b1, 2);
        check(!ch_done, "R6 done cleared on re-enable", {31'h0, ch_done}, 0);
        pulse(); push_block();
        drain();

        // R7 R6: strobe disabled, total 2 ends mid-block of 4, src hold
        setup(16'h0300, 16'h0A00, 2, 3, 1'b1, 3, 1, 1'b0, 1'b0, 1'b0, 0);
        pulse(); push_block();
        drain();
        check(!ch_enable && ch_done, "R6 total ends block early",
              {30'h0, ch_enable, ch_done}, 32'h1);
        check(q.size() == 0, "R1 scoreboard empty", q.size(), 0);
        check(xfer_ack == 1'b0, "R8 ack low at end", {31'h0, xfer_ack}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule